// File: doc/BRIEF.md
# Registered Register-Versus-Bus Comparator

The block keeps one byte in a clocked register and compares it at all times with the value on a shared bidirectional data bus. A two-bit select chooses one of four operations on each rising clock edge: keep the value, shift it one place toward the top bit through a serial input, capture the bus, or put the register on the bus. The serial output is always the register's top bit.

The comparison is combinational and gives three flags: register equal to bus, register greater, register smaller. A mode input chooses unsigned magnitude or two's complement order. A status enable gates the three flags. Separate link inputs and ungated link outputs let several slices form a longer word. A slice whose bytes match passes the result from the slice below it. A slice whose bytes differ gives its own result. Only the slice marked as most significant reads its top bit as a sign.

Top module: `byte_bus_comparator`

## Requirements
- R1: While reset is asserted, the register clears to zero, so `bus_out` reads 0.
- R2: With `sel` = 00, a clock edge leaves the register unchanged.
- R3: With `sel` = 01, a clock edge makes the register `{reg[W-2:0], ser_in}`. `ser_out` always equals register bit W-1.
- R4: With `sel` = 10, a clock edge captures `bus_in` into the register.
- R5: `bus_oe` is 1 only while `sel` = 11. `bus_out` always carries the register value.
- R6: With `signed_mode` = 0, or with `top_slice` = 0, the bytes are compared as unsigned values. The link outputs `{eq,gt,lt}` are one-hot when the link inputs are one-hot.
- R7: With `signed_mode` = 1 and `top_slice` = 1, both bytes are compared as two's complement numbers. For example, 0x80 is less than 0x7F.
- R8: When the register equals the bus, the link outputs copy the link inputs. Otherwise the local result drives them, and the link inputs have no effect.
- R9: With `stat_en` = 0, `flag_eq`, `flag_gt` and `flag_lt` are all 0. With `stat_en` = 1, they equal the link outputs.
- R10: Take two slices. The lower slice has `top_slice` = 0 and link inputs tied to equal (1,0,0). The upper slice has `top_slice` = 1 and takes the lower slice's link outputs. Together they compare 16-bit words correctly in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Operation: 00 hold, 01 shift, 10 load, 11 drive bus |
| ser_in | input | 1 | Serial bit that enters at bit 0 |
| ser_out | output | 1 | Register bit W-1 |
| bus_in | input | WIDTH | Value currently on the bus |
| bus_out | output | WIDTH | Register value offered to the bus |
| bus_oe | output | 1 | Bus drive enable |
| signed_mode | input | 1 | 1 selects two's complement order |
| top_slice | input | 1 | 1 marks the most significant slice |
| link_eq_in | input | 1 | Equal result from the lower slice |
| link_gt_in | input | 1 | Greater result from the lower slice |
| link_lt_in | input | 1 | Less result from the lower slice |
| link_eq_out | output | 1 | Cascaded equal result |
| link_gt_out | output | 1 | Cascaded greater result |
| link_lt_out | output | 1 | Cascaded less result |
| stat_en | input | 1 | Status enable for the flags |
| flag_eq | output | 1 | Gated equal flag |
| flag_gt | output | 1 | Gated greater flag |
| flag_lt | output | 1 | Gated less flag |

## Verification
A load and a comparison can happen in the same cycle. During a load, the flags compare the old register with the bus value that is about to be captured. The bench checks the flags for the old contents just before the edge, then checks that they read equal just after it. A drive cycle also compares the register with itself through the modelled tri-state bus, and the flags must show equality.

// File: rtl/byte_bus_comparator.sv
module byte_bus_comparator #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic             ser_in,
  output logic             ser_out,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  input  logic             signed_mode,
  input  logic             top_slice,
  input  logic             link_eq_in,
  input  logic             link_gt_in,
  input  logic             link_lt_in,
  output logic             link_eq_out,
  output logic             link_gt_out,
  output logic             link_lt_out,
  input  logic             stat_en,
  output logic             flag_eq,
  output logic             flag_gt,
  output logic             flag_lt
);
  localparam logic [1:0] OP_SHIFT = 2'b01;
  localparam logic [1:0] OP_LOAD  = 2'b10;
  localparam logic [1:0] OP_DRIVE = 2'b11;

  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] a_key, b_key;
  logic             flip, same, above, below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else begin
      case (sel)
        OP_SHIFT: store_q <= {store_q[WIDTH-2:0], ser_in};
        OP_LOAD:  store_q <= bus_in;
        default:  store_q <= store_q;
      endcase
    end
  end

  assign ser_out = store_q[WIDTH-1];
  assign bus_out = store_q;
  assign bus_oe  = (sel == OP_DRIVE);

  assign flip  = signed_mode & top_slice;
  assign a_key = {store_q[WIDTH-1] ^ flip, store_q[WIDTH-2:0]};
  assign b_key = {bus_in[WIDTH-1] ^ flip, bus_in[WIDTH-2:0]};
  assign same  = (a_key == b_key);
  assign above = (a_key > b_key);
  assign below = (a_key < b_key);

  assign link_eq_out = same & link_eq_in;
  assign link_gt_out = same ? link_gt_in : above;
  assign link_lt_out = same ? link_lt_in : below;

  assign flag_eq = stat_en & link_eq_out;
  assign flag_gt = stat_en & link_gt_out;
  assign flag_lt = stat_en & link_lt_out;
endmodule

module byte_bus_comparator_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       sel,
  input logic             ser_in,
  input logic [WIDTH-1:0] bus_in,
  input logic [WIDTH-1:0] bus_out,
  input logic             link_eq_in,
  input logic             link_gt_in,
  input logic             link_lt_in,
  input logic             link_eq_out,
  input logic             link_gt_out,
  input logic             link_lt_out,
  input logic             stat_en,
  input logic             flag_eq,
  input logic             flag_gt,
  input logic             flag_lt
);
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00) |=> $stable(bus_out)); // R2
  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b01) |=> (bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_in)})); // R3
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b10) |=> (bus_out == $past(bus_in))); // R4
  AST_LINK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({link_eq_in, link_gt_in, link_lt_in}) |->
      $onehot({link_eq_out, link_gt_out, link_lt_out})); // R6
  AST_EQ_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    link_eq_out |-> (bus_in == bus_out)); // R8
  AST_FLAGS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_en |-> ({flag_eq, flag_gt, flag_lt} == 3'b000)); // R9
endmodule

bind byte_bus_comparator byte_bus_comparator_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/byte_bus_comparator_tb.sv
module byte_bus_comparator_tb_top;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [1:0] sel = 0;
  logic ser_in = 0, signed_mode = 0, top_slice = 1, stat_en = 1;
  logic leq = 1, lgt = 0, llt = 0;
  logic [W-1:0] tb_bus = 0;
  logic [W-1:0] bus_in, bus_out;
  logic ser_out, bus_oe, oeq, ogt, olt, feq, fgt, flt;
  int n_chk = 0, n_fail = 0, cycles = 0;

  assign bus_in = bus_oe ? bus_out : tb_bus;

  byte_bus_comparator #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ser_in(ser_in), .ser_out(ser_out),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .signed_mode(signed_mode), .top_slice(top_slice),
    .link_eq_in(leq), .link_gt_in(lgt), .link_lt_in(llt),
    .link_eq_out(oeq), .link_gt_out(ogt), .link_lt_out(olt),
    .stat_en(stat_en), .flag_eq(feq), .flag_gt(fgt), .flag_lt(flt));

  logic [1:0] c_sel = 0;
  logic c_sgn = 0;
  logic [15:0] c_bus = 0;
  logic [W-1:0] lo_out, hi_out;
  logic lo_se, hi_se, lo_oe, hi_oe, le, lg, ll, he, hg, hl, hfe, hfg, hfl, lfe, lfg, lfl;

  byte_bus_comparator #(.WIDTH(W)) lo_i (
    .clk(clk), .rst_n(rst_n), .sel(c_sel), .ser_in(1'b0), .ser_out(lo_se),
    .bus_in(c_bus[7:0]), .bus_out(lo_out), .bus_oe(lo_oe),
    .signed_mode(c_sgn), .top_slice(1'b0),
    .link_eq_in(1'b1), .link_gt_in(1'b0), .link_lt_in(1'b0),
    .link_eq_out(le), .link_gt_out(lg), .link_lt_out(ll),
    .stat_en(1'b1), .flag_eq(lfe), .flag_gt(lfg), .flag_lt(lfl));
  byte_bus_comparator #(.WIDTH(W)) hi_i (
    .clk(clk), .rst_n(rst_n), .sel(c_sel), .ser_in(lo_se), .ser_out(hi_se),
    .bus_in(c_bus[15:8]), .bus_out(hi_out), .bus_oe(hi_oe),
    .signed_mode(c_sgn), .top_slice(1'b1),
    .link_eq_in(le), .link_gt_in(lg), .link_lt_in(ll),
    .link_eq_out(he), .link_gt_out(hg), .link_lt_out(hl),
    .stat_en(1'b1), .flag_eq(hfe), .flag_gt(hfg), .flag_lt(hfl));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_cmp(input int a, input int b);
    return {a == b, a > b, a < b};
  endfunction

  function automatic int sval(input logic [W-1:0] v, input bit sgn);
    return (sgn && v[W-1]) ? int'(v) - (1 << W) : int'(v);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [W-1:0] v);
    tb_bus = v; sel = 2'b10; tick(); sel = 2'b00;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        check(1'b0, "watchdog", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    logic [W-1:0] exp_reg;
    logic [31:0] lfsr;
    #3;
    check(bus_out == 0, "R1 reset value", bus_out, 0);
    tick(); tick(); rst_n = 1; tick();
    check(bus_out == 0, "R1 after release", bus_out, 0);

    load(8'hA5);
    check(bus_out == 8'hA5, "R4 load", bus_out, 8'hA5);
    tb_bus = 8'h3C; sel = 2'b00; tick(); tick();
    check(bus_out == 8'hA5, "R2 hold ignores bus", bus_out, 8'hA5);
    check(bus_oe == 0, "R5 oe low on hold", bus_oe, 0);

    exp_reg = 8'hA5;
    for (int i = 0; i < 12; i++) begin
      ser_in = (i % 3 == 0); sel = 2'b01;
      exp_reg = {exp_reg[W-2:0], ser_in};
      tick();
      check(bus_out == exp_reg, "R3 shift order", bus_out, exp_reg);
      check(ser_out == exp_reg[W-1], "R3 serial out", ser_out, exp_reg[W-1]);
    end
    sel = 2'b00;

    sel = 2'b11; tb_bus = 8'h00; #1;
    check(bus_oe == 1, "R5 oe on drive", bus_oe, 1);
    check(bus_in == exp_reg, "R5 bus carries register", bus_in, exp_reg);
    check({feq, fgt, flt} == 3'b100, "R5 drive compares equal", {feq, fgt, flt}, 3'b100);
    tick();
    check(bus_out == exp_reg, "R5 drive keeps register", bus_out, exp_reg);
    sel = 2'b00;

    load(8'h10); tb_bus = 8'h20; sel = 2'b10; #1;
    check({feq, fgt, flt} == 3'b001, "R4 flags before load edge", {feq, fgt, flt}, 3'b001);
    tick(); sel = 2'b00; #1;
    check({feq, fgt, flt} == 3'b100, "R4 flags after load edge", {feq, fgt, flt}, 3'b100);

    load(8'h80); tb_bus = 8'h7F;
    signed_mode = 0; #1;
    check({feq, fgt, flt} == 3'b010, "R6 0x80>0x7F unsigned", {feq, fgt, flt}, 3'b010);
    signed_mode = 1; #1;
    check({feq, fgt, flt} == 3'b001, "R7 0x80<0x7F signed", {feq, fgt, flt}, 3'b001);
    top_slice = 0; #1;
    check({feq, fgt, flt} == 3'b010, "R6 lower slice unsigned", {feq, fgt, flt}, 3'b010);
    top_slice = 1; signed_mode = 0;

    stat_en = 0; #1;
    check({feq, fgt, flt} == 3'b000, "R9 flags off", {feq, fgt, flt}, 3'b000);
    check({oeq, ogt, olt} == 3'b010, "R9 links unaffected", {oeq, ogt, olt}, 3'b010);
    stat_en = 1;

    leq = 0; lgt = 0; llt = 1; #1;
    check({oeq, ogt, olt} == 3'b010, "R8 local wins on mismatch", {oeq, ogt, olt}, 3'b010);
    tb_bus = 8'h80; #1;
    check({oeq, ogt, olt} == 3'b001, "R8 pass-through lt", {oeq, ogt, olt}, 3'b001);
    leq = 0; lgt = 1; llt = 0; #1;
    check({feq, fgt, flt} == 3'b010, "R8 pass-through gt", {feq, fgt, flt}, 3'b010);
    leq = 1; lgt = 0; llt = 0;

    for (int r = 0; r < 256; r++) begin
      load(r[W-1:0]);
      for (int b = 0; b < 256; b++) begin
        for (int m = 0; m < 3; m++) begin
          logic [2:0] e;
          tb_bus = b[W-1:0];
          signed_mode = (m != 0);
          top_slice = (m != 2);
          stat_en = ((b + r) % 7 != 0);
          #1;
          e = ref_cmp(sval(r[W-1:0], m == 1), sval(b[W-1:0], m == 1));
          if (!stat_en) e = 3'b000;
          check({feq, fgt, flt} == e, m == 1 ? "R7 signed sweep" : "R6 unsigned sweep",
                {feq, fgt, flt}, e);
        end
      end
    end
    stat_en = 1; top_slice = 1; signed_mode = 0;

    lfsr = 32'h1234_5678;
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a, bb;
      logic [2:0] e;
      int av, bv;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      a = lfsr[31:16];
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      bb = (k % 5 == 0) ? a : (k % 5 == 1) ? {a[15:8], lfsr[23:16]} : lfsr[31:16];
      if (k == 0) begin a = 16'h8000; bb = 16'h7FFF; end
      c_sgn = k[0];
      c_bus = a; c_sel = 2'b10; tick(); c_sel = 2'b00;
      c_bus = bb; #1;
      av = c_sgn ? int'($signed(a)) : int'(a);
      bv = c_sgn ? int'($signed(bb)) : int'(bb);
      e = ref_cmp(av, bv);
      check({hfe, hfg, hfl} == e, "R10 16-bit cascade", {hfe, hfg, hfl}, e);
    end

    finish_run();
  end
endmodule